// File: doc/BRIEF.md
# Scaler Shadow Register Bank

This block holds the configuration of a two-dimensional image scaler: a control word that carries a per-direction enable and an up/down choice, five scale-ratio registers (luma horizontal, Cb horizontal, Cr horizontal, luma vertical, shared chroma vertical) and four phase registers. Each of these registers has two copies. Software writes the working copy. The scaling datapath sees only the shadow copy. Software can read either copy back over a simple single-cycle register bus.

A commit copies every working register into its shadow at once. Software requests it through one of two self-clearing bits in the control word. The immediate bit commits on the edge that takes the write. The automatic bit arms a commit that waits for the next `frame_end` pulse, so a frame already in flight keeps a consistent setting. The block also holds a 64-entry interpolation table. Software loads it by writing an index register and then a data register. The datapath reads the table through its own read port.

Bus writes take effect on the rising edge where `bus_we` is high. `bus_rdata` is a combinational function of `bus_addr` and the current register state. Word addresses are as follows. Working registers sit at 0 to 9: control, scale luma-H, scale Cb-H, scale Cr-H, scale luma-V, scale chroma-V, phase luma-H, phase chroma-H, phase luma-V, phase chroma-V. Table index is at 10 and table data at 11. The shadow copy of working register n reads at 16+n. Any other address reads 0.

Top module: `scaler_shadow_bank`

## Requirements
- R1: After reset every working and shadow register, the table index and all datapath outputs are zero.
- R2: Control word bits 0..3 enable luma horizontal, chroma horizontal, luma vertical and chroma vertical scaling. Bits 4..7 select upscaling (1) or downscaling (0) for the same four directions in the same order. Once committed, they appear on `dp_enable` and `dp_up`.
- R3: A write to a working register is visible at once at its working address. The shadow readback (address 16+n) and the datapath outputs stay unchanged until a commit.
- R4: A control write with bit 8 set copies all working registers into their shadows on that same edge. The copy includes the value carried by that write.
- R5: A control write with bit 9 set (and bit 8 clear) arms a commit. The copy happens on the first cycle where `frame_end` is high, and not before. The copy takes the working values present at that point, and the armed state is then cleared.
- R6: When bits 8 and 9 are set in the same write, the immediate commit wins and nothing stays armed. A later `frame_end` copies nothing.
- R7: Bits 8 and 9 are not stored. Reading the control word returns them as 0.
- R8: Committing a control word of zero disables all four scaling directions (`dp_enable` = 0).
- R9: A write to address 11 stores the entry selected by the last value written to address 10. The index does not auto-increment. Reading address 11 returns the selected entry, and `lut_rd_val` returns the entry at `lut_rd_idx`.
- R10: The five scale registers are independent. Cb and Cr have separate horizontal registers, and one register serves vertical chroma.
- R11: A `frame_end` pulse with no armed commit leaves every shadow register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for bus_addr |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| dp_enable | output | 4 | Committed direction enables |
| dp_up | output | 4 | Committed up/down selects |
| dp_scale_hy | output | REG_W | Committed luma horizontal ratio |
| dp_scale_hcb | output | REG_W | Committed Cb horizontal ratio |
| dp_scale_hcr | output | REG_W | Committed Cr horizontal ratio |
| dp_scale_vy | output | REG_W | Committed luma vertical ratio |
| dp_scale_vc | output | REG_W | Committed chroma vertical ratio |
| dp_phase_hy | output | REG_W | Committed luma horizontal phase |
| dp_phase_hc | output | REG_W | Committed chroma horizontal phase |
| dp_phase_vy | output | REG_W | Committed luma vertical phase |
| dp_phase_vc | output | REG_W | Committed chroma vertical phase |
| lut_rd_idx | input | 6 | Datapath table read index |
| lut_rd_val | output | LUT_W | Table entry at lut_rd_idx |

## Verification
The bench goes after commit timing. A bank that copied on every write would move the datapath outputs before any commit. A bank that dropped the carried value would commit the stale control word when the update bit rides in the same write. It also probes the armed path. A design that ignored the arm would never copy, and one that copied on any `frame_end` would disturb a frame with no commit pending. Writing both update bits at once catches a bank that leaves the arm set and then copies a second time. A full sweep of the control word and of all 64 table entries, including repeated data writes to one index, exposes swapped bit fields and an index that wrongly advances.

// File: rtl/scaler_shd_pkg.sv
package scaler_shd_pkg;
  localparam int ADDR_W     = 5;
  localparam int NDATA      = 9;   // scale x5 + phase x4
  localparam int A_CTRL     = 0;
  localparam int A_DATA0    = 1;
  localparam int A_LUT_IDX  = 10;
  localparam int A_LUT_DATA = 11;
  localparam int SHD_BIT    = 4;   // address bit selecting shadow view
  localparam int CTRL_W     = 8;
  localparam int BIT_NOW    = 8;
  localparam int BIT_AUTO   = 9;
endpackage

// File: rtl/scaler_shd_field.sv
module scaler_shd_field #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             commit,
  output logic [WIDTH-1:0] work,
  output logic [WIDTH-1:0] shad
);
  logic [WIDTH-1:0] work_nx;
  assign work_nx = wr ? wdata : work;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work <= '0;
      shad <= '0;
    end else begin
      work <= work_nx;
      if (commit) shad <= work_nx;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(shad)); // R3
  AST_COMMIT_TAKES_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> (shad == $past(work))); // R4
  AST_COMMIT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr) |=> (shad == $past(wdata))); // R4
endmodule

// File: rtl/scaler_shd_commit.sv
module scaler_shd_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic now_bit,
  input  logic auto_bit,
  input  logic frame_end,
  output logic commit,
  output logic pending
);
  logic req_now, req_auto;
  assign req_now  = ctrl_wr && now_bit;
  assign req_auto = ctrl_wr && auto_bit && !now_bit;
  assign commit   = req_now || (pending && frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n)                      pending <= 1'b0;
    else if (req_now)                pending <= 1'b0;
    else if (req_auto)               pending <= 1'b1;
    else if (frame_end && pending)   pending <= 1'b0;
  end

  AST_NOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_now |=> !pending); // R6
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    req_auto |=> pending); // R5
  AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && frame_end && !ctrl_wr) |=> !pending); // R5
endmodule

// File: rtl/scaler_lut.sv
module scaler_lut #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  AST_LUT_STORE: assert property (@(posedge clk)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R9
endmodule

// File: rtl/scaler_shadow_bank.sv
module scaler_shadow_bank
  import scaler_shd_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int LUT_DEPTH = 64,
  parameter int LUT_W     = 10,
  localparam int LUT_AW   = $clog2(LUT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              frame_end,
  output logic [3:0]        dp_enable,
  output logic [3:0]        dp_up,
  output logic [REG_W-1:0]  dp_scale_hy,
  output logic [REG_W-1:0]  dp_scale_hcb,
  output logic [REG_W-1:0]  dp_scale_hcr,
  output logic [REG_W-1:0]  dp_scale_vy,
  output logic [REG_W-1:0]  dp_scale_vc,
  output logic [REG_W-1:0]  dp_phase_hy,
  output logic [REG_W-1:0]  dp_phase_hc,
  output logic [REG_W-1:0]  dp_phase_vy,
  output logic [REG_W-1:0]  dp_phase_vc,
  input  logic [LUT_AW-1:0] lut_rd_idx,
  output logic [LUT_W-1:0]  lut_rd_val
);
  logic              ctrl_wr, commit, pending;
  logic [CTRL_W-1:0] ctrl_work, ctrl_shad;
  logic [REG_W-1:0]  work_q [NDATA];
  logic [REG_W-1:0]  shad_q [NDATA];
  logic [LUT_AW-1:0] lut_idx_q;
  logic [LUT_W-1:0]  lut_bus_val;
  logic              lut_we;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign lut_we  = bus_we && (bus_addr == ADDR_W'(A_LUT_DATA));

  scaler_shd_commit u_commit (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .now_bit(bus_wdata[BIT_NOW]), .auto_bit(bus_wdata[BIT_AUTO]),
    .frame_end(frame_end), .commit(commit), .pending(pending));

  scaler_shd_field #(.WIDTH(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata[CTRL_W-1:0]),
    .commit(commit), .work(ctrl_work), .shad(ctrl_shad));

  for (genvar g = 0; g < NDATA; g++) begin : g_data
    logic wr_g;
    assign wr_g = bus_we && (bus_addr == ADDR_W'(A_DATA0 + g));
    scaler_shd_field #(.WIDTH(REG_W)) u_fld (
      .clk(clk), .rst_n(rst_n), .wr(wr_g), .wdata(bus_wdata),
      .commit(commit), .work(work_q[g]), .shad(shad_q[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lut_idx_q <= '0;
    else if (bus_we && (bus_addr == ADDR_W'(A_LUT_IDX)))
      lut_idx_q <= bus_wdata[LUT_AW-1:0];
  end

  scaler_lut #(.DEPTH(LUT_DEPTH), .WIDTH(LUT_W)) u_lut (
    .clk(clk), .we(lut_we), .waddr(lut_idx_q), .wdata(bus_wdata[LUT_W-1:0]),
    .raddr_a(lut_idx_q), .rdata_a(lut_bus_val),
    .raddr_b(lut_rd_idx), .rdata_b(lut_rd_val));

  assign dp_enable    = ctrl_shad[3:0];
  assign dp_up        = ctrl_shad[7:4];
  assign dp_scale_hy  = shad_q[0];
  assign dp_scale_hcb = shad_q[1];
  assign dp_scale_hcr = shad_q[2];
  assign dp_scale_vy  = shad_q[3];
  assign dp_scale_vc  = shad_q[4];
  assign dp_phase_hy  = shad_q[5];
  assign dp_phase_hc  = shad_q[6];
  assign dp_phase_vy  = shad_q[7];
  assign dp_phase_vc  = shad_q[8];

  always_comb begin
    logic [SHD_BIT-1:0] idx;
    idx       = bus_addr[SHD_BIT-1:0];
    bus_rdata = '0;
    if (bus_addr[SHD_BIT]) begin
      if (idx == SHD_BIT'(A_CTRL))
        bus_rdata = REG_W'(ctrl_shad);
      else if (idx >= SHD_BIT'(A_DATA0) && idx < SHD_BIT'(A_DATA0 + NDATA))
        bus_rdata = shad_q[idx - SHD_BIT'(A_DATA0)];
    end else begin
      if (idx == SHD_BIT'(A_CTRL))
        bus_rdata = REG_W'(ctrl_work);
      else if (idx >= SHD_BIT'(A_DATA0) && idx < SHD_BIT'(A_DATA0 + NDATA))
        bus_rdata = work_q[idx - SHD_BIT'(A_DATA0)];
      else if (idx == SHD_BIT'(A_LUT_IDX))
        bus_rdata = REG_W'(lut_idx_q);
      else if (idx == SHD_BIT'(A_LUT_DATA))
        bus_rdata = REG_W'(lut_bus_val);
    end
  end

  AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !pending && !bus_we) |=> ($stable(dp_enable) && $stable(dp_scale_hy))); // R11
  AST_UPD_BITS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_CTRL)) |-> (bus_rdata[REG_W-1:CTRL_W] == '0)); // R7
  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[BIT_NOW] && bus_wdata[3:0] == 4'd0) |=> (dp_enable == 4'd0)); // R8
endmodule

// File: tb/tb_scaler_shadow_bank.sv
`timescale 1ns/1ps
module tb_scaler_shadow_bank;
  localparam int REG_W = 16;
  localparam int LUT_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [4:0]        bus_addr = '0;
  logic [REG_W-1:0]  bus_wdata = '0;
  logic [REG_W-1:0]  bus_rdata;
  logic              frame_end = 1'b0;
  logic [3:0]        dp_enable, dp_up;
  logic [REG_W-1:0]  dp_scale_hy, dp_scale_hcb, dp_scale_hcr, dp_scale_vy, dp_scale_vc;
  logic [REG_W-1:0]  dp_phase_hy, dp_phase_hc, dp_phase_vy, dp_phase_vc;
  logic [5:0]        lut_rd_idx = '0;
  logic [LUT_W-1:0]  lut_rd_val;

  int n_chk = 0;
  int n_bad = 0;
  logic [REG_W-1:0] wk [9];
  logic [REG_W-1:0] sh [9];

  always #10 clk = ~clk;

  scaler_shadow_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end(frame_end),
    .dp_enable(dp_enable), .dp_up(dp_up),
    .dp_scale_hy(dp_scale_hy), .dp_scale_hcb(dp_scale_hcb), .dp_scale_hcr(dp_scale_hcr),
    .dp_scale_vy(dp_scale_vy), .dp_scale_vc(dp_scale_vc),
    .dp_phase_hy(dp_phase_hy), .dp_phase_hc(dp_phase_hc),
    .dp_phase_vy(dp_phase_vy), .dp_phase_vc(dp_phase_vc),
    .lut_rd_idx(lut_rd_idx), .lut_rd_val(lut_rd_val));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [REG_W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [REG_W-1:0] d);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  function automatic logic [REG_W-1:0] dp_of(input int i);
    case (i)
      0: return dp_scale_hy;  1: return dp_scale_hcb; 2: return dp_scale_hcr;
      3: return dp_scale_vy;  4: return dp_scale_vc;  5: return dp_phase_hy;
      6: return dp_phase_hc;  7: return dp_phase_vy;  default: return dp_phase_vc;
    endcase
  endfunction

  task automatic check_all(input string req);
    logic [REG_W-1:0] v;
    for (int i = 0; i < 9; i++) begin
      rd(1 + i, v);  check({req, " working"}, v, wk[i]);
      rd(17 + i, v); check({req, " shadow"}, v, sh[i]);
      check({req, " dp"}, dp_of(i), sh[i]);
    end
  endtask

  initial begin
    logic [REG_W-1:0] v;
    for (int i = 0; i < 9; i++) begin wk[i] = '0; sh[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1");
    check("R1 enable", dp_enable, 0);
    check("R1 up", dp_up, 0);
    rd(10, v); check("R1 lut idx", v, 0);

    // R3 / R10: distinct values in every register, shadows untouched
    for (int i = 0; i < 9; i++) begin
      wk[i] = 16'h1000 * (i + 1) + 16'h0011 * i + 16'h3;
      wr(1 + i, wk[i]);
    end
    check_all("R3 R10 before commit");

    // R4: immediate commit carrying the control value itself
    wr(0, 16'h0100 | 16'h00A5);
    for (int i = 0; i < 9; i++) sh[i] = wk[i];
    check_all("R4");
    check("R4 enable", dp_enable, 4'h5);
    check("R4 up", dp_up, 4'hA);
    rd(0, v); check("R7 ctrl read", v, 16'h00A5);

    // R11: frame_end without armed commit
    wk[0] = 16'hBEEF; wr(1, wk[0]);
    pulse_frame();
    check_all("R11");

    // R5: armed commit waits for frame_end, one-shot
    wk[3] = 16'h0F0F; wr(4, wk[3]);
    wr(0, 16'h0200 | 16'h003C);
    check_all("R5 armed, no frame yet");
    check("R5 enable held", dp_enable, 4'h5);
    rd(0, v); check("R7 auto bit hidden", v, 16'h003C);
    repeat (4) @(negedge clk);
    wk[8] = 16'h7777; wr(9, wk[8]);
    pulse_frame();
    for (int i = 0; i < 9; i++) sh[i] = wk[i];
    check_all("R5 after frame");
    check("R5 enable", dp_enable, 4'hC);
    check("R5 up", dp_up, 4'h3);
    wk[1] = 16'h2222; wr(2, wk[1]);
    pulse_frame();
    check_all("R5 one-shot");

    // R6: both bits, immediate wins, nothing remains armed
    wk[2] = 16'h3333; wr(3, wk[2]);
    wr(0, 16'h0300 | 16'h000F);
    for (int i = 0; i < 9; i++) sh[i] = wk[i];
    check_all("R6 immediate");
    check("R6 enable", dp_enable, 4'hF);
    wk[4] = 16'h4444; wr(5, wk[4]);
    pulse_frame();
    check_all("R6 no arm left");

    // R2: sweep every control value
    for (int c = 0; c < 256; c++) begin
      wr(0, 16'h0100 | 16'(c));
      check("R2 enable", dp_enable, c[3:0]);
      check("R2 up", dp_up, c[7:4]);
    end
    for (int i = 0; i < 9; i++) sh[i] = wk[i];
    check_all("R2 data after sweep");

    // R8: commit zero control
    wr(0, 16'h0100);
    check("R8 enable", dp_enable, 0);
    check("R8 up", dp_up, 0);
    rd(16, v); check("R8 shadow ctrl", v, 0);

    // R9: fill table, check both read ports
    for (int i = 0; i < 64; i++) begin
      wr(10, 16'(i));
      wr(11, 16'((i * 37 + 5) % 1024));
    end
    for (int i = 0; i < 64; i++) begin
      lut_rd_idx = 6'(i);
      #1 check("R9 dp port", lut_rd_val, (i * 37 + 5) % 1024);
    end
    // no auto-increment: two data writes land on one index
    wr(10, 16'd20);
    wr(11, 16'h0111);
    wr(11, 16'h0222);
    rd(10, v); check("R9 idx kept", v, 20);
    rd(11, v); check("R9 bus read", v, 16'h0222);
    lut_rd_idx = 6'd21;
    #1 check("R9 neighbour untouched", lut_rd_val, (21 * 37 + 5) % 1024);
    lut_rd_idx = 6'd20;
    #1 check("R9 overwrite", lut_rd_val, 10'h222);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule